// File: doc/BRIEF.md
# Program/Erase Status Read Generator

This block chooses the byte that a flash-style memory drives onto its 8-bit data bus when the host reads it. While an internally timed program or erase operation is running, the byte carries two completion indicators that the host can poll. One is a polarity bit: during a program it is the inverse of the top bit of the byte being written, and during an erase it is the inverse of the erased level. The other is a toggle bit that changes value on every read. When no operation is running, the byte is the true array data.

A neighbouring sequencer supplies the busy flag and the operation type, and the command path supplies the byte most recently loaded for programming. The array supplies read data. A one-cycle read strobe marks each completed host read. On the clock edge where the strobe is high, the output register captures the selected byte, and it then holds that byte until the next strobe. The toggle state changes only on strobes taken while busy. It returns to zero whenever busy is low, so the first status read of every operation is known in advance. The host may start polling on the same cycle the operation starts, and it sees array data on its first read after the operation ends.

Top module: `status_read_mux`

## Requirements
- R1: After synchronous reset, `rd_data_o` is 0x00, and the first status read that follows shows bit 6 = 0.
- R2: A strobe taken with `busy_i` low loads all eight bits of `array_i` into `rd_data_o`. The new value appears one clock after the strobe edge.
- R3: A strobe taken with `busy_i` high and `erase_i` low (program) sets `rd_data_o[7]` to the inverse of `loaded_i[7]`.
- R4: A strobe taken with `busy_i` high and `erase_i` high (erase) sets `rd_data_o[7]` to 0, the inverse of the erased level 1.
- R5: While busy, `rd_data_o[6]` alternates on successive strobes: 0, 1, 0, … from the first strobe of the operation.
- R6: Clock cycles without a strobe do not advance the toggle state, whatever the number of idle cycles between reads.
- R7: Any cycle with `busy_i` low clears the toggle state. The next operation's first status read therefore shows bit 6 = 0, however many reads the previous operation had.
- R8: `rd_data_o` holds its value on every cycle without a strobe, including across changes of `busy_i`, `array_i` and `loaded_i`.
- R9: A strobe in the same cycle that `busy_i` first goes high returns status: bit 6 = 0, and bit 7 follows R3 or R4.
- R10: The first strobe taken after `busy_i` falls returns true array data, with no extra cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_i | input | 1 | An internally timed operation is in progress |
| erase_i | input | 1 | Operation type: 1 = erase, 0 = program |
| loaded_i | input | 8 | Byte most recently loaded for programming |
| array_i | input | 8 | Array read data for the current address |
| rd_stb_i | input | 1 | One-cycle pulse for each completed host read |
| rd_data_o | output | 8 | Registered byte returned to the host |

## Verification
The bench targets the toggle parity across operation boundaries. A design that carried the toggle state from one operation into the next would show bit 6 = 1 on the first read after an odd number of earlier reads. It also spaces reads with long and uneven idle gaps, which exposes a toggle that advances per clock instead of per strobe. Reads are placed on the very cycle busy rises and on the first cycle after it falls: a design with a setup delay would return array data at the start of the operation, and one with a drain delay would return stale status at the end. Program reads use both values of the loaded top bit and erase reads check a fixed 0, which catches a polarity bit that is not inverted or that ignores the operation type.

// File: rtl/srg_pkg.sv
package srg_pkg;
  typedef enum logic {
    OP_PROGRAM = 1'b0,
    OP_ERASE   = 1'b1
  } op_kind_e;

  typedef struct packed {
    logic busy;
    logic strobe;
    logic erase;
  } rd_ctl_t;
endpackage

// File: rtl/srg_toggle.sv
module srg_toggle (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  input  logic strobe,
  output logic tog_q
);
  logic tog_d;

  always_comb begin
    if (!busy)       tog_d = 1'b0;
    else if (strobe) tog_d = ~tog_q;
    else             tog_d = tog_q;
  end

  always_ff @(posedge clk) begin
    if (rst) tog_q <= 1'b0;
    else     tog_q <= tog_d;
  end

  assert_clear_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !tog_q);
  assert_advance_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && strobe) |=> (tog_q != $past(tog_q)));
  assert_no_idle_step_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && !strobe) |=> $stable(tog_q));
endmodule

// File: rtl/srg_compose.sv
module srg_compose
  import srg_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOG_BIT    = 6,
  parameter bit ERASED_LVL = 1'b1
) (
  input  rd_ctl_t           ctl,
  input  logic              tog,
  input  logic [DATA_W-1:0] loaded,
  input  logic [DATA_W-1:0] array_rd,
  output logic [DATA_W-1:0] sel
);
  localparam logic ERASE_POLL = ~ERASED_LVL;

  op_kind_e kind;
  logic     poll_val;

  assign kind = op_kind_e'(ctl.erase);

  always_comb begin
    poll_val = (kind == OP_ERASE) ? ERASE_POLL : ~loaded[POLL_BIT];
    sel = array_rd;
    if (ctl.busy) begin
      sel[POLL_BIT] = poll_val;
      sel[TOG_BIT]  = tog;
    end
  end
endmodule

// File: rtl/srg_outreg.sv
module srg_outreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));
endmodule

// File: rtl/status_read_mux.sv
module status_read_mux
  import srg_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOG_BIT    = 6,
  parameter bit ERASED_LVL = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy_i,
  input  logic              erase_i,
  input  logic [DATA_W-1:0] loaded_i,
  input  logic [DATA_W-1:0] array_i,
  input  logic              rd_stb_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam logic ERASE_POLL = ~ERASED_LVL;

  rd_ctl_t           ctl;
  logic              tog;
  logic [DATA_W-1:0] sel;

  assign ctl = '{busy: busy_i, strobe: rd_stb_i, erase: erase_i};

  srg_toggle u_tog (
    .clk    (clk),
    .rst    (rst),
    .busy   (busy_i),
    .strobe (rd_stb_i),
    .tog_q  (tog)
  );

  srg_compose #(
    .DATA_W     (DATA_W),
    .POLL_BIT   (POLL_BIT),
    .TOG_BIT    (TOG_BIT),
    .ERASED_LVL (ERASED_LVL)
  ) u_comp (
    .ctl      (ctl),
    .tog      (tog),
    .loaded   (loaded_i),
    .array_rd (array_i),
    .sel      (sel)
  );

  srg_outreg #(.DATA_W(DATA_W)) u_out (
    .clk  (clk),
    .rst  (rst),
    .load (rd_stb_i),
    .d    (sel),
    .q    (rd_data_o)
  );

  assert_true_data_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_stb_i && !busy_i) |=> (rd_data_o == $past(array_i)));
  assert_prog_poll_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_stb_i && busy_i && !erase_i) |=> (rd_data_o[POLL_BIT] == !$past(loaded_i[POLL_BIT])));
  assert_erase_poll_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_stb_i && busy_i && erase_i) |=> (rd_data_o[POLL_BIT] == ERASE_POLL));
  assert_first_read_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_stb_i && $rose(busy_i)) |=> !rd_data_o[TOG_BIT]);
endmodule

// File: tb/status_read_mux_test.sv
module status_read_mux_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       busy_i, erase_i, rd_stb_i;
  logic [7:0] loaded_i, array_i;
  logic [7:0] rd_data_o;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string cur_req = "R1";

  // behavioural reference
  int m_data = 0;
  int m_mask = 255;
  bit m_tog = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_read_mux uut (
    .clk(clk), .rst(rst), .busy_i(busy_i), .erase_i(erase_i),
    .loaded_i(loaded_i), .array_i(array_i), .rd_stb_i(rd_stb_i),
    .rd_data_o(rd_data_o)
  );

  always @(posedge clk) begin
    int v;
    cycles++;
    if (rst) begin
      m_data = 0; m_mask = 255; m_tog = 0;
    end else begin
      if (rd_stb_i) begin
        if (busy_i) begin
          v = int'(array_i) & 63;
          if (!erase_i && loaded_i[7] == 1'b0) v += 128;
          if (m_tog) v += 64;
          m_data = v; m_mask = 192;
          m_tog = !m_tog;
        end else begin
          m_data = int'(array_i); m_mask = 255;
        end
      end
      if (!busy_i) m_tog = 0;
    end
  end

  always @(negedge clk) begin
    compared++;
    if ((int'(rd_data_o) & m_mask) != (m_data & m_mask)) begin
      mismatched++;
      $display("FAIL %s: rd_data_o=%02h expected=%02h (mask %02h) t=%0t",
               cur_req, rd_data_o, m_data[7:0], m_mask[7:0], $time);
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp,
                     input logic [7:0] mask);
    compared++;
    if ((act & mask) != (exp & mask)) begin
      mismatched++;
      $display("FAIL %s: actual=%02h expected=%02h mask=%02h", req, act, exp, mask);
    end
  endtask

  task automatic step(input logic b, input logic e, input logic [7:0] ld,
                      input logic [7:0] arr, input logic s);
    @(negedge clk);
    busy_i = b; erase_i = e; loaded_i = ld; array_i = arr; rd_stb_i = s;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_stb_i = 1'b0;
      array_i = 8'($urandom);
      loaded_i = 8'($urandom);
    end
  endtask

  initial begin
    rst = 1'b1; busy_i = 0; erase_i = 0; loaded_i = 0; array_i = 0; rd_stb_i = 0;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1", rd_data_o, 8'h00, 8'hFF);
    rst = 1'b0;

    // R9/R1: read on the cycle busy rises (program, loaded bit7 = 0)
    cur_req = "R9";
    step(1, 0, 8'h12, 8'h3C, 1);
    @(negedge clk); rd_stb_i = 0;
    chk("R9", rd_data_o, 8'h80, 8'hC0);
    chk("R1", rd_data_o, 8'h00, 8'h40);

    // R5/R6: successive reads with uneven gaps
    cur_req = "R5";
    step(1, 0, 8'h92, 8'h00, 1);
    @(negedge clk); rd_stb_i = 0;
    chk("R5", rd_data_o, 8'h40, 8'hC0);  // loaded bit7=1 -> poll 0, toggle 1
    cur_req = "R6";
    idle(7);
    step(1, 0, 8'h92, 8'h00, 1);
    @(negedge clk); rd_stb_i = 0;
    chk("R6", rd_data_o, 8'h00, 8'hC0);  // toggle back to 0
    cur_req = "R8";
    idle(5);
    chk("R8", rd_data_o, 8'h00, 8'hC0);

    // R10: busy falls, immediate read returns array
    cur_req = "R10";
    step(0, 0, 8'h92, 8'hA5, 1);
    @(negedge clk); rd_stb_i = 0;
    chk("R10", rd_data_o, 8'hA5, 8'hFF);

    // R7: odd number of reads, then new operation starts at 0
    cur_req = "R7";
    step(1, 1, 8'h00, 8'h00, 1);
    step(1, 1, 8'h00, 8'h00, 0);
    step(1, 1, 8'h00, 8'h00, 1);
    step(1, 1, 8'h00, 8'h00, 1);  // three reads -> toggle now 1
    step(0, 1, 8'h00, 8'h5A, 0);
    step(1, 1, 8'h00, 8'hFF, 1);
    @(negedge clk); rd_stb_i = 0;
    chk("R7", rd_data_o, 8'h00, 8'hC0);
    chk("R4", rd_data_o, 8'h00, 8'h80);

    // R2: idle reads of various patterns
    cur_req = "R2";
    busy_i = 0;
    foreach (array_i[k]) begin
      step(0, k[0], 8'hFF, 8'(1 << k), 1);
      @(negedge clk); rd_stb_i = 0;
      chk("R2", rd_data_o, 8'(1 << k), 8'hFF);
    end

    // R3/R4 mixed random operations
    cur_req = "R3";
    for (int op = 0; op < 40; op++) begin
      logic er;
      logic [7:0] ld;
      er = 1'($urandom);
      ld = 8'($urandom);
      cur_req = er ? "R4" : "R3";
      for (int r = 0; r < 1 + int'($urandom % 6); r++) begin
        step(1, er, ld, 8'($urandom), 1'($urandom));
      end
      step(1, er, ld, 8'($urandom), 1);
      @(negedge clk); rd_stb_i = 0;
      chk(er ? "R4" : "R3", rd_data_o, er ? 8'h00 : {~ld[7], 7'h0}, 8'h80);
      cur_req = "R10";
      step(0, er, ld, 8'($urandom), 1'($urandom));
      idle(int'($urandom % 3));
    end

    idle(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual=%0d cycles expected=under 100000", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule